// File: doc/BRIEF.md
# Multi-String PWM Dimming Generator

This block drives the on/off enables of several LED strings for PWM dimming. A prescaler divides the system clock by a programmable divisor plus one. A period counter then runs over 512 prescaled ticks in the fast mode or 1024 in the slow mode. Each string is lit while its position in the period, advanced by an optional per-string offset, is below its duty code. The duty code comes either from a filtered external value or from a per-string register value. In the fast mode the code is first halved, which leaves 9 bits of resolution.

A source bit chooses between this internal generator and direct pass-through. In pass-through every string copies the raw external PWM input in the same cycle, and phase staggering and duty source have no effect. All control and duty inputs are captured into shadow registers only at a period boundary, and once in the first cycle after reset. A change made in the middle of a period therefore never cuts a pulse short.

Top module: `pwm_dim_gen`

## Requirements
- R1: When the captured source bit int_pwm_i is 0, every bit of str_en_o equals ext_pwm_i in the same cycle, whatever phase_en_i and duty_int_i hold.
- R2: With hi_freq_i=1 captured, one period lasts 512*(div_i+1) clock cycles. The 10-bit duty code is shifted right by one before it is compared.
- R3: With hi_freq_i=0 captured, one period lasts 1024*(div_i+1) clock cycles, and the full 10-bit code is compared. The period counter advances only once per div_i+1 cycles.
- R4: duty_int_i=0 takes every string's duty from ext_duty_i. duty_int_i=1 takes string k's duty from duty_regs_i[10k+9:10k].
- R5: In internal mode string k is high exactly while (count + offset_k) mod P < d, where P is 512 or 1024 and d is the effective duty. It is therefore high for d*(div_i+1) cycles per period.
- R6: An effective duty of 0 keeps a string low for the whole period. An effective duty of P-1 (code 1023 slow, 1022 or 1023 fast) is clamped to constant high.
- R7: With phase_en_i=1, offset_k = k*P/N_STR, so with 4 strings in slow mode the offsets are 0, 256, 512, 768. With phase_en_i=0 every offset is 0.
- R8: All control, divisor and duty inputs are sampled only on the clock edge that ends the last tick of a period. A change at any other time has no effect until then.
- R9: Reset clears both counters and sets the captured state to pass-through, slow mode, divisor 0 and all duties 0. The first clock edge after reset captures the inputs and starts count 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_freq_i | input | 1 | 1: 512-tick period, 9-bit duty; 0: 1024-tick period, 10-bit duty |
| phase_en_i | input | 1 | Stagger strings across the period |
| duty_int_i | input | 1 | 1: per-string register duty; 0: external duty |
| int_pwm_i | input | 1 | 1: internal generator; 0: pass-through |
| div_i | input | DIV_W | Prescale divisor; tick every div_i+1 cycles |
| duty_regs_i | input | N_STR*DUTY_W | Per-string duty codes, string k at [10k+9:10k] |
| ext_duty_i | input | DUTY_W | Filtered external duty code |
| ext_pwm_i | input | 1 | Raw external PWM |
| str_en_o | output | N_STR | String enables |

## Verification
The case of most interest is a period boundary that falls in the same cycle as a change of mode, divisor or duty. The last tick of the old period and the capture of the new settings then share one edge. The bench provokes this by predicting the boundary edge from its own model and changing all inputs in the half cycle just before it. Other segments change the inputs at random points in mid-period. Every cycle is judged against a bench model that captures settings only on boundaries, and directed high-time counts confirm that a mid-period duty change leaves the current period untouched.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;

  typedef struct packed {
    logic int_pwm;
    logic hi_freq;
    logic phase_en;
    logic duty_int;
  } mode_t;

  localparam mode_t MODE_RST = '{int_pwm: 1'b0, hi_freq: 1'b0, phase_en: 1'b0, duty_int: 1'b0};

endpackage

// File: rtl/pwm_dim_shadow.sv
module pwm_dim_shadow
  import pwm_dim_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DUTY_W = 10,
  parameter int REG_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  mode_t             mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [REG_W-1:0]  regs_i,
  input  logic [DUTY_W-1:0] ext_i,
  output mode_t             mode_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [REG_W-1:0]  regs_o,
  output logic [DUTY_W-1:0] ext_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
      div_o  <= '0;
      regs_o <= '0;
      ext_o  <= '0;
    end else if (load_i) begin
      mode_o <= mode_i;
      div_o  <= div_i;
      regs_o <= regs_i;
      ext_o  <= ext_i;
    end
  end

endmodule

// File: rtl/pwm_dim_timebase.sv
module pwm_dim_timebase #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hi_freq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             reload_o
);

  logic             start_q;
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = hi_freq_i ? {1'b0, {(CNT_W-1){1'b1}}} : {CNT_W{1'b1}};
  assign tick_o   = (pre_q == div_i);
  assign reload_o = start_q | (tick_o & (cnt_q == last));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (reload_o) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick_o) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_dim_lane.sv
module pwm_dim_lane #(
  parameter int N_STR  = 4,
  parameter int IDX    = 0,
  parameter int DUTY_W = 10
) (
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              hi_freq_i,
  input  logic              phase_en_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              on_o
);

  localparam logic [DUTY_W-1:0] OFF_LO = DUTY_W'(IDX * (1 << DUTY_W) / N_STR);
  localparam logic [DUTY_W-1:0] OFF_HI = DUTY_W'(IDX * (1 << (DUTY_W-1)) / N_STR);

  logic [DUTY_W-1:0] off;
  logic [DUTY_W-1:0] sum;
  logic [DUTY_W-1:0] pos;
  logic [DUTY_W-1:0] deff;
  logic              full;

  always_comb begin
    off  = phase_en_i ? (hi_freq_i ? OFF_HI : OFF_LO) : '0;
    sum  = cnt_i + off;
    pos  = hi_freq_i ? {1'b0, sum[DUTY_W-2:0]} : sum;
    deff = hi_freq_i ? {1'b0, duty_i[DUTY_W-1:1]} : duty_i;
    full = hi_freq_i ? (&duty_i[DUTY_W-1:1]) : (&duty_i);
    on_o = full | (pos < deff);
  end

endmodule

// File: rtl/pwm_dim_gen.sv
module pwm_dim_gen
  import pwm_dim_pkg::*;
#(
  parameter int N_STR  = 4,
  parameter int DIV_W  = 8,
  parameter int DUTY_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hi_freq_i,
  input  logic                    phase_en_i,
  input  logic                    duty_int_i,
  input  logic                    int_pwm_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic [N_STR*DUTY_W-1:0] duty_regs_i,
  input  logic [DUTY_W-1:0]       ext_duty_i,
  input  logic                    ext_pwm_i,
  output logic [N_STR-1:0]        str_en_o
);

  localparam int CNT_W = DUTY_W;
  localparam int REG_W = N_STR * DUTY_W;

  mode_t             mode_in;
  mode_t             mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [REG_W-1:0]  regs_q;
  logic [DUTY_W-1:0] ext_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick;
  logic              reload;
  logic [N_STR-1:0]  lane_on;

  assign mode_in = '{int_pwm: int_pwm_i, hi_freq: hi_freq_i,
                     phase_en: phase_en_i, duty_int: duty_int_i};

  pwm_dim_shadow #(.DIV_W(DIV_W), .DUTY_W(DUTY_W), .REG_W(REG_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (reload),
    .mode_i (mode_in),
    .div_i  (div_i),
    .regs_i (duty_regs_i),
    .ext_i  (ext_duty_i),
    .mode_o (mode_q),
    .div_o  (div_q),
    .regs_o (regs_q),
    .ext_o  (ext_q)
  );

  pwm_dim_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .hi_freq_i (mode_q.hi_freq),
    .cnt_o     (cnt_q),
    .tick_o    (tick),
    .reload_o  (reload)
  );

  for (genvar k = 0; k < N_STR; k++) begin : g_lane
    logic [DUTY_W-1:0] duty_sel;
    assign duty_sel = mode_q.duty_int ? regs_q[k*DUTY_W +: DUTY_W] : ext_q;

    pwm_dim_lane #(.N_STR(N_STR), .IDX(k), .DUTY_W(DUTY_W)) u_lane (
      .cnt_i      (cnt_q),
      .hi_freq_i  (mode_q.hi_freq),
      .phase_en_i (mode_q.phase_en),
      .duty_i     (duty_sel),
      .on_o       (lane_on[k])
    );
  end

  // pass-through is combinational so the external edge is not delayed
  assign str_en_o = mode_q.int_pwm ? lane_on : {N_STR{ext_pwm_i}};

endmodule

// File: rtl/pwm_dim_chk.sv
module pwm_dim_chk
  import pwm_dim_pkg::*;
#(
  parameter int N_STR  = 4,
  parameter int DIV_W  = 8,
  parameter int DUTY_W = 10,
  parameter int REG_W  = 40,
  parameter int CNT_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input mode_t             mode_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [REG_W-1:0]  regs_q,
  input logic [DUTY_W-1:0] ext_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              tick,
  input logic              reload,
  input logic              ext_pwm_i,
  input logic [N_STR-1:0]  str_en_o
);

  assert_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.int_pwm |-> str_en_o == {N_STR{ext_pwm_i}});

  assert_hi_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.hi_freq |-> !cnt_q[CNT_W-1]);

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !reload) |=> $stable(cnt_q));

  assert_zero_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.int_pwm && !mode_q.duty_int && ext_q == '0) |-> str_en_o == '0);

  assert_full_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.int_pwm && !mode_q.duty_int && (&ext_q)) |-> str_en_o == {N_STR{1'b1}});

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload |=> $stable({mode_q, div_q, regs_q, ext_q}));

  assert_reload_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> cnt_q == '0);

endmodule

bind pwm_dim_gen pwm_dim_chk #(
  .N_STR(N_STR), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_q    (mode_q),
  .div_q     (div_q),
  .regs_q    (regs_q),
  .ext_q     (ext_q),
  .cnt_q     (cnt_q),
  .tick      (tick),
  .reload    (reload),
  .ext_pwm_i (ext_pwm_i),
  .str_en_o  (str_en_o)
);

// File: tb/pwm_dim_gen_bench.sv
module pwm_dim_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 10;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hi = 0, ph = 0, sel = 0, intp = 0, ext_pwm = 0;
  logic [7:0]    div = 0;
  logic [N*DW-1:0] regs = 0;
  logic [DW-1:0] ext_duty = 0;
  logic [N-1:0]  str_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // bench reference state
  logic m_start, m_hi, m_ph, m_sel, m_int, m_just;
  int   m_pre, m_cnt, m_div, m_ext;
  logic [N*DW-1:0] m_regs;
  int   hc [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dim_gen u_pwm_dim_gen (
    .clk_i(clk), .rst_ni(rst_n), .hi_freq_i(hi), .phase_en_i(ph), .duty_int_i(sel),
    .int_pwm_i(intp), .div_i(div), .duty_regs_i(regs), .ext_duty_i(ext_duty),
    .ext_pwm_i(ext_pwm), .str_en_o(str_en)
  );

  function automatic int per_of(logic h);
    return h ? 512 : 1024;
  endfunction

  function automatic logic pred_reload();
    return m_start || (m_pre == m_div && m_cnt == per_of(m_hi) - 1);
  endfunction

  function automatic logic [N-1:0] model_out();
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      int p, d, de, off, pos;
      p   = per_of(m_hi);
      d   = m_sel ? int'(m_regs[k*DW +: DW]) : m_ext;
      de  = m_hi ? d / 2 : d;
      off = m_ph ? k * p / N : 0;
      pos = (m_cnt + off) % p;
      r[k] = (de == p - 1) || (pos < de);
    end
    if (!m_int) r = {N{ext_pwm}};
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 1; m_pre = 0; m_cnt = 0; m_div = 0; m_ext = 0; m_regs = '0;
      m_hi = 0; m_ph = 0; m_sel = 0; m_int = 0; m_just = 0;
    end else begin
      logic rl, tk;
      tk = (m_pre == m_div);
      rl = pred_reload();
      m_just = rl;
      if (rl) begin
        m_pre = 0; m_cnt = 0;
        m_hi = hi; m_ph = ph; m_sel = sel; m_int = intp;
        m_div = int'(div); m_ext = int'(ext_duty); m_regs = regs;
      end else if (tk) begin
        m_pre = 0; m_cnt = m_cnt + 1;
      end else begin
        m_pre = m_pre + 1;
      end
      m_start = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle, compared against the model (R1 R4 R5 R6 R7 R8 covered per cycle)
  task automatic step();
    logic [N-1:0] e;
    @(negedge clk);
    e = model_out();
    checks++;
    if (str_en !== e) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%b expected=%b",
               m_int ? "R4 R5 R6 R7 R8" : "R1 R8", cyc, str_en, e);
    end
  endtask

  task automatic sync_boundary();
    do step(); while (!m_just);
  endtask

  task automatic count_period(input int len, input logic mid_change);
    for (int k = 0; k < N; k++) hc[k] = 0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) step();
      for (int k = 0; k < N; k++) hc[k] += int'(str_en[k]);
      if (mid_change && i == len / 2) begin
        regs = {N{10'd5}};
        ext_duty = 10'd5;
      end
    end
  endtask

  task automatic set_cfg(input logic h, input logic p, input logic s, input logic ip,
                         input int dv, input int ed);
    hi = h; ph = p; sel = s; intp = ip; div = 8'(dv); ext_duty = DW'(ed);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R9: reset state is pass-through
    repeat (3) @(negedge clk);
    check("R9 reset out low", int'(str_en), 0);
    ext_pwm = 1;
    @(negedge clk);
    check("R9 reset out follows ext", int'(str_en), 15);
    ext_pwm = 0;
    rst_n = 1;

    // R9: first edge captures; low duty code from registers
    set_cfg(0, 0, 1, 1, 0, 0);
    regs = {10'd40, 10'd30, 10'd20, 10'd10};
    step();
    check("R9 first edge capture", int'(str_en), 15);
    for (int i = 1; i < 1024; i++) step();

    // R4 R5: per-string register duty counts, slow mode, div 1
    set_cfg(0, 0, 1, 1, 1, 0);
    regs = {10'd700, 10'd3, 10'd512, 10'd100};
    sync_boundary();
    count_period(2048, 1'b0);
    check("R4 R5 string0 high", hc[0], 200);
    check("R4 R5 string1 high", hc[1], 1024);
    check("R4 R5 string2 high", hc[2], 6);
    check("R4 R5 string3 high", hc[3], 1400);

    // R6: duty zero and full scale from ext source
    set_cfg(0, 0, 0, 1, 0, 0);
    sync_boundary();
    count_period(1024, 1'b0);
    check("R6 zero duty low", hc[2], 0);
    set_cfg(0, 0, 0, 1, 0, 1023);
    sync_boundary();
    count_period(1024, 1'b0);
    check("R6 full scale high", hc[1], 1024);

    // R2 R6: fast mode halves code; 1022 clamps high, 601 gives 300 ticks
    set_cfg(1, 1, 1, 1, 2, 0);
    regs = {10'd1022, 10'd601, 10'd601, 10'd0};
    sync_boundary();
    count_period(1536, 1'b0);
    check("R2 fast string1 halved", hc[1], 900);
    check("R6 fast 1022 clamps high", hc[3], 1536);
    check("R6 fast zero low", hc[0], 0);

    // R7: phase stagger positions, slow mode
    set_cfg(0, 1, 0, 1, 0, 256);
    sync_boundary();
    check("R7 phase at count 0", int'(str_en), 1);
    for (int i = 0; i < 768; i++) step();
    check("R7 phase at count 768", int'(str_en), 2);
    set_cfg(0, 0, 0, 1, 0, 256);
    sync_boundary();
    check("R7 no phase aligned", int'(str_en), 15);

    // R8: mid-period duty change ignored until boundary
    set_cfg(0, 0, 1, 1, 0, 5);
    regs = {N{10'd400}};
    sync_boundary();
    count_period(1024, 1'b1);
    check("R8 mid-period change ignored", hc[0], 400);
    count_period(1024, 1'b0);
    check("R8 new duty at boundary", hc[0], 5);

    // R3: slow period length with div 1
    set_cfg(0, 0, 0, 1, 1, 300);
    sync_boundary();
    begin
      int n = 0;
      do begin step(); n++; end while (!(str_en[0] && n > 700));
      check("R3 slow period cycles", n, 2048);
    end
    // R2: fast period length with div 1
    set_cfg(1, 0, 0, 1, 1, 300);
    sync_boundary();
    begin
      int n = 0;
      do begin step(); n++; end while (!(str_en[0] && n > 400));
      check("R2 fast period cycles", n, 1024);
    end

    // R1: pass-through ignores phase and duty source
    set_cfg(0, 1, 1, 0, 0, 77);
    sync_boundary();
    for (int i = 0; i < 200; i++) begin
      ph = 1'($urandom); sel = 1'($urandom);
      ext_pwm = 1'($urandom);
      step();
    end
    ext_pwm = 1;
    step();
    check("R1 pass-through high", int'(str_en), 15);

    // random segments; every third change lands on the boundary edge
    for (int seg = 0; seg < 24; seg++) begin
      int len = 300 + int'($urandom % 2500);
      if (seg % 3 == 0) while (!pred_reload()) step();
      hi = 1'($urandom); ph = 1'($urandom); sel = 1'($urandom);
      intp = ($urandom % 5) != 0;
      div = 8'($urandom % 3);
      for (int k = 0; k < N; k++) begin
        int r = int'($urandom % 8);
        regs[k*DW +: DW] = (r == 0) ? 10'd0 : (r == 1) ? 10'd1023 : DW'($urandom);
      end
      ext_duty = DW'($urandom);
      for (int i = 0; i < len; i++) begin
        ext_pwm = 1'($urandom);
        step();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule